// File: doc/BRIEF.md
# Byte-Wide Slave Parallel Configuration Loader

This block pushes a configuration image into a programmable target device through its byte-wide slave parallel port. A single-cycle `start` together with a byte count begins a load. The controller first pulses the target's program line for a fixed number of system clocks. It then waits until the target signals that it is ready. Next it raises chip select and write, with the configuration clock parked high, and takes image bytes one at a time from a ready/valid stream. Each byte is presented on the data bus and followed by one low-then-high clock pulse. The target captures the byte on the rising edge.

If the target reports busy after a clock pulse, the same byte stays on the bus and the clock keeps pulsing until busy clears. Once the last byte has been accepted, chip select and write drop. The clock then keeps pulsing until the target reports done. Each of the three waits (ready, busy and done) is guarded by its own timeout of `TIMEOUT_CYC` system clocks, which defaults to 10 ms at 50 MHz. When a load ends, the block holds a completion flag and a 2-bit result code until the next start. On any timeout it also pulses an abort output for one cycle. Every target line is active-high at this boundary; any pad inversion is done outside the block.

Top module: `cfg_loader`

## Requirements
- R1: After `start`, `cfgProg` is high for exactly `PROG_CYC` system clocks. `cfgCs` and `cfgWr` stay low while it is high.
- R2: After `cfgProg` falls, the controller waits for `tgtInit` high with `tgtBusy` low. If that has not happened after `TIMEOUT_CYC` clocks of waiting (counted from the fall of `cfgProg`), the load ends with status 01.
- R3: `cfgCs` and `cfgWr` rise and fall together. When they rise, `cfgClk` is already high. Every byte-capturing rising edge of `cfgClk` occurs with both of them high.
- R4: For each byte, `cfgClk` is low for `HALF_DIV` clocks and then high for `HALF_DIV` clocks. `cfgData` is stable across each rising edge. The target receives exactly `byteCount` bytes, in stream order.
- R5: If `tgtBusy` is high at the end of a high phase, the same byte is held and the clock pulses again. If this stall outlasts `TIMEOUT_CYC` clocks from the byte's acceptance, the load ends with status 10.
- R6: Once the last byte is accepted, `cfgCs` and `cfgWr` fall before any further clock edge. A byte count of zero goes straight to this point.
- R7: With `cfgCs` low, the clock pulses until `tgtDone` is seen high at the end of a high phase, so the number of pulses equals the number of edges the target needs. If done does not arrive within `TIMEOUT_CYC` clocks, the load ends with status 11.
- R8: `inReady` is high only while the controller waits for a byte and `tgtBusy` is low. A byte is consumed only on `inValid && inReady`.
- R9: Status encoding is 00 success, 01 ready timeout, 10 busy timeout, 11 done timeout. `finished` and `status` hold until the next `start`. `abort` is a single-cycle pulse, issued only together with a nonzero status.
- R10: A `start` given after any finished load, successful or failed, runs a complete new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle load request, honoured when idle or finished |
| byteCount | input | CNT_W | Number of image bytes, sampled with `start` |
| inData | input | 8 | Image byte from the stream |
| inValid | input | 1 | Stream byte valid |
| inReady | output | 1 | Controller accepts a stream byte |
| cfgProg | output | 1 | Program request to the target |
| cfgCs | output | 1 | Chip select to the target |
| cfgWr | output | 1 | Write enable to the target |
| cfgClk | output | 1 | Configuration clock, parked high |
| cfgData | output | 8 | Configuration data bus |
| tgtInit | input | 1 | Target init released (ready) |
| tgtBusy | input | 1 | Target busy |
| tgtDone | input | 1 | Target configuration done |
| finished | output | 1 | Load ended, result valid |
| status | output | 2 | Result code |
| abort | output | 1 | One-cycle failure pulse |

## Verification
A corrupted sequencer state shows up on the target pins within one clock-pulse period. Possible symptoms are a clock edge with chip select low while bytes remain, a byte that changes between repeated busy pulses, or a low phase of the wrong length. A wrong byte counter or a mis-gated handshake appears as a byte stream at the target that differs from the one sent, and the bench compares the two at the end of each load. A faulty timer shows up as a wrong result code or as a ready-wait length that differs from `TIMEOUT_CYC`.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_WINIT, S_SETUP, S_GETB,
    S_LOW, S_HIGH, S_TAIL, S_DLOW, S_DHIGH, S_END
  } ldState_t;

  localparam logic [1:0] RES_OK       = 2'b00;
  localparam logic [1:0] RES_INIT_TO  = 2'b01;
  localparam logic [1:0] RES_BUSY_TO  = 2'b10;
  localparam logic [1:0] RES_DONE_TO  = 2'b11;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic       loadCount;
    logic       decCount;
    logic       loadByte;
    logic       clrTimer;
    logic       clrDiv;
    logic       setStatus;
    logic [1:0] statusCode;
  } dpCmd_t;

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HALF_DIV    = 2,
  parameter int PROG_CYC    = 50,
  parameter int TIMEOUT_CYC = 500000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] countIn,
  input  logic [7:0]       byteIn,
  output logic [7:0]       dataOut,
  output logic [1:0]       status,
  output logic             countZero,
  output logic             countOne,
  output logic             divEnd,
  output logic             progEnd,
  output logic             timeHit
);

  localparam int TMAX  = (TIMEOUT_CYC > PROG_CYC) ? TIMEOUT_CYC : PROG_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int DW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [TW-1:0] T_SAT   = TW'(TMAX);
  localparam logic [TW-1:0] T_PROG  = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] T_LIMIT = TW'(TIMEOUT_CYC - 1);
  localparam logic [DW-1:0] D_LAST  = DW'(HALF_DIV - 1);

  logic [CNT_W-1:0] remaining;
  logic [TW-1:0]    timer;
  logic [DW-1:0]    divCnt;

  // bytes still to send
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              remaining <= '0;
    else if (cmd.loadCount) remaining <= countIn;
    else if (cmd.decCount)  remaining <= remaining - 1'b1;
  end

  // byte presented on the target bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dataOut <= '0;
    else if (cmd.loadByte) dataOut <= byteIn;
  end

  // shared phase timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timer <= '0;
    else if (cmd.clrTimer)  timer <= '0;
    else if (timer != T_SAT) timer <= timer + 1'b1;
  end

  // half-period divider for the configuration clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               divCnt <= '0;
    else if (cmd.clrDiv)     divCnt <= '0;
    else if (divCnt == D_LAST) divCnt <= '0;
    else                     divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              status <= RES_OK;
    else if (cmd.setStatus) status <= cmd.statusCode;
  end

  assign countZero = (remaining == '0);
  assign countOne  = (remaining == CNT_W'(1));
  assign divEnd    = (divCnt == D_LAST);
  assign progEnd   = (timer == T_PROG);
  assign timeHit   = (timer >= T_LIMIT);

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter bit BUSY_CHECK = 1'b1
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   inValid,
  input  logic   tgtInit,
  input  logic   tgtBusy,
  input  logic   tgtDone,
  input  logic   countZero,
  input  logic   countOne,
  input  logic   divEnd,
  input  logic   progEnd,
  input  logic   timeHit,
  output dpCmd_t cmd,
  output logic   cfgProg,
  output logic   cfgCs,
  output logic   cfgWr,
  output logic   cfgClk,
  output logic   inReady,
  output logic   finished,
  output logic   abort
);

  ldState_t state, stateNext;
  logic     stall, stallNext;
  logic     abortNext;
  logic     busyGate;

  generate
    if (BUSY_CHECK) begin : g_busyChk
      assign busyGate = tgtBusy;
    end else begin : g_noBusyChk
      assign busyGate = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      stall <= 1'b0;
      abort <= 1'b0;
    end else begin
      state <= stateNext;
      stall <= stallNext;
      abort <= abortNext;
    end
  end

  always_comb begin
    stateNext = state;
    stallNext = stall;
    abortNext = 1'b0;
    cmd       = '0;
    unique case (state)
      S_IDLE, S_END: begin
        if (start) begin
          cmd.loadCount = 1'b1;
          cmd.clrTimer  = 1'b1;
          stateNext     = S_PROG;
        end
      end
      S_PROG: begin
        if (progEnd) begin
          cmd.clrTimer = 1'b1;
          stateNext    = S_WINIT;
        end
      end
      S_WINIT: begin
        if (tgtInit && !tgtBusy) begin
          stateNext = S_SETUP;
        end else if (timeHit) begin
          cmd.setStatus  = 1'b1;
          cmd.statusCode = RES_INIT_TO;
          abortNext      = 1'b1;
          stateNext      = S_END;
        end
      end
      S_SETUP: begin
        stateNext = countZero ? S_TAIL : S_GETB;
      end
      S_GETB: begin
        if (inValid && !tgtBusy) begin
          cmd.loadByte = 1'b1;
          cmd.clrTimer = 1'b1;
          cmd.clrDiv   = 1'b1;
          stallNext    = 1'b0;
          stateNext    = S_LOW;
        end
      end
      S_LOW: begin
        if (stall && timeHit) begin
          cmd.setStatus  = 1'b1;
          cmd.statusCode = RES_BUSY_TO;
          abortNext      = 1'b1;
          stateNext      = S_END;
        end else if (divEnd) begin
          cmd.clrDiv = 1'b1;
          stateNext  = S_HIGH;
        end
      end
      S_HIGH: begin
        if (divEnd) begin
          cmd.clrDiv = 1'b1;
          if (busyGate) begin
            stallNext = 1'b1;
            if (timeHit) begin
              cmd.setStatus  = 1'b1;
              cmd.statusCode = RES_BUSY_TO;
              abortNext      = 1'b1;
              stateNext      = S_END;
            end else begin
              stateNext = S_LOW;
            end
          end else begin
            cmd.decCount = 1'b1;
            stateNext    = countOne ? S_TAIL : S_GETB;
          end
        end
      end
      S_TAIL: begin
        cmd.clrTimer = 1'b1;
        cmd.clrDiv   = 1'b1;
        if (tgtDone) begin
          cmd.setStatus  = 1'b1;
          cmd.statusCode = RES_OK;
          stateNext      = S_END;
        end else begin
          stateNext = S_DLOW;
        end
      end
      S_DLOW: begin
        if (timeHit) begin
          cmd.setStatus  = 1'b1;
          cmd.statusCode = RES_DONE_TO;
          abortNext      = 1'b1;
          stateNext      = S_END;
        end else if (divEnd) begin
          cmd.clrDiv = 1'b1;
          stateNext  = S_DHIGH;
        end
      end
      S_DHIGH: begin
        if (divEnd && tgtDone) begin
          cmd.setStatus  = 1'b1;
          cmd.statusCode = RES_OK;
          stateNext      = S_END;
        end else if (timeHit) begin
          cmd.setStatus  = 1'b1;
          cmd.statusCode = RES_DONE_TO;
          abortNext      = 1'b1;
          stateNext      = S_END;
        end else if (divEnd) begin
          cmd.clrDiv = 1'b1;
          stateNext  = S_DLOW;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign cfgProg  = (state == S_PROG);
  assign cfgCs    = (state == S_SETUP) || (state == S_GETB) ||
                    (state == S_LOW)   || (state == S_HIGH);
  assign cfgWr    = cfgCs;
  assign cfgClk   = !((state == S_LOW) || (state == S_DLOW));
  assign inReady  = (state == S_GETB) && !tgtBusy;
  assign finished = (state == S_END);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int HALF_DIV    = 2,
  parameter int PROG_CYC    = 50,
  parameter int TIMEOUT_CYC = 500000,
  parameter bit BUSY_CHECK  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             cfgProg,
  output logic             cfgCs,
  output logic             cfgWr,
  output logic             cfgClk,
  output logic [7:0]       cfgData,
  input  logic             tgtInit,
  input  logic             tgtBusy,
  input  logic             tgtDone,
  output logic             finished,
  output logic [1:0]       status,
  output logic             abort
);

  dpCmd_t cmd;
  logic   countZero, countOne, divEnd, progEnd, timeHit;

  cfg_loader_ctrl #(.BUSY_CHECK(BUSY_CHECK)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .tgtInit(tgtInit), .tgtBusy(tgtBusy), .tgtDone(tgtDone),
    .countZero(countZero), .countOne(countOne), .divEnd(divEnd),
    .progEnd(progEnd), .timeHit(timeHit), .cmd(cmd),
    .cfgProg(cfgProg), .cfgCs(cfgCs), .cfgWr(cfgWr), .cfgClk(cfgClk),
    .inReady(inReady), .finished(finished), .abort(abort)
  );

  cfg_loader_dp #(
    .CNT_W(CNT_W), .HALF_DIV(HALF_DIV),
    .PROG_CYC(PROG_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .countIn(byteCount),
    .byteIn(inData), .dataOut(cfgData), .status(status),
    .countZero(countZero), .countOne(countOne), .divEnd(divEnd),
    .progEnd(progEnd), .timeHit(timeHit)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgProg,
  input logic       cfgCs,
  input logic       cfgWr,
  input logic       cfgClk,
  input logic [7:0] cfgData,
  input logic       inReady,
  input logic       tgtBusy,
  input logic       finished,
  input logic [1:0] status,
  input logic       abort
);

  p_prog_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgProg && cfgCs));

  p_cswr_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    cfgCs == cfgWr);

  p_byte_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cfgClk) && cfgCs) |-> $stable(cfgData));

  p_end_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> (!cfgCs && !cfgProg && cfgClk));

  p_ready_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!tgtBusy && cfgCs && cfgWr));

  p_abort_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> !abort);

  p_abort_fail_r9: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> (finished && status != 2'b00));

  p_status_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (finished && $past(finished)) |-> $stable(status));

endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgProg(cfgProg), .cfgCs(cfgCs), .cfgWr(cfgWr),
  .cfgClk(cfgClk), .cfgData(cfgData), .inReady(inReady), .tgtBusy(tgtBusy),
  .finished(finished), .status(status), .abort(abort)
);

// File: tb/sim_cfg_loader.sv
module sim_cfg_loader;

  localparam int CNT_W = 8;
  localparam int HALF  = 2;
  localparam int PROGC = 5;
  localparam int TOUT  = 300;
  localparam int NEVER = 1000000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] byteCount = '0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0;
  logic tgtInit = 1'b0, tgtBusy = 1'b0, tgtDone = 1'b0;
  logic inReady, cfgProg, cfgCs, cfgWr, cfgClk, finished, abort;
  logic [7:0] cfgData;
  logic [1:0] status;

  always #10 clk = ~clk;

  cfg_loader #(.CNT_W(CNT_W), .HALF_DIV(HALF), .PROG_CYC(PROGC),
               .TIMEOUT_CYC(TOUT), .BUSY_CHECK(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .inData(inData), .inValid(inValid), .inReady(inReady),
    .cfgProg(cfgProg), .cfgCs(cfgCs), .cfgWr(cfgWr), .cfgClk(cfgClk),
    .cfgData(cfgData), .tgtInit(tgtInit), .tgtBusy(tgtBusy),
    .tgtDone(tgtDone), .finished(finished), .status(status), .abort(abort)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] tx [0:31];
  logic [7:0] cap [0:31];
  int stallTab [0:31];
  int nBytes, initDelay, doneAfter;
  int idx, capIdx, progCnt, waitCnt, initCnt, lowCnt, dEdges, abortCnt, stallLeft;
  int holdVio, earlyVio, csWrVio, widthVio, readyVio;
  bit armed, csEver, inStall, hsPending, clkPrev, csPrev;
  logic [7:0] edgeData;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one system clock; target model and stream driver act at the falling edge
  task automatic tick;
    bit rise;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    rise = cfgClk && !clkPrev;
    if (armed) begin
      if (cfgProg) progCnt++;
      if (!cfgProg && progCnt > 0 && !csEver && !finished) waitCnt++;
      if (cfgProg) begin
        tgtInit = 1'b0; initCnt = 0;
      end else if (!tgtInit && progCnt > 0) begin
        initCnt++;
        if (initCnt >= initDelay) tgtInit = 1'b1;
      end
      if (cfgCs && !csPrev) begin
        csEver = 1'b1;
        if (!cfgClk) csWrVio++;
      end
      if (cfgCs != cfgWr) csWrVio++;
      if (!cfgClk) lowCnt++;
      if (rise) begin
        if (lowCnt != HALF) widthVio++;
        lowCnt = 0;
        if (cfgCs) begin
          if (capIdx >= nBytes) earlyVio++;
          else if (!inStall) begin
            edgeData = cfgData;
            if (stallTab[capIdx] > 0) begin
              stallLeft = stallTab[capIdx]; inStall = 1'b1; tgtBusy = 1'b1;
            end else begin
              cap[capIdx] = cfgData; capIdx++;
            end
          end else begin
            if (cfgData != edgeData) holdVio++;
            stallLeft--;
            if (stallLeft == 0) begin
              inStall = 1'b0; tgtBusy = 1'b0;
              cap[capIdx] = edgeData; capIdx++;
            end
          end
        end else if (csEver) begin
          if (capIdx < nBytes) earlyVio++;
          dEdges++;
        end
      end
      if (!cfgCs && csEver && capIdx >= nBytes && dEdges >= doneAfter) tgtDone = 1'b1;
      if (inReady && (tgtBusy || !cfgCs)) readyVio++;
      if (abort) abortCnt++;
      if (hsPending) idx++;
      if (idx < nBytes) begin
        if (!inValid) inValid = (($urandom % 3) != 0);
        inData = tx[idx];
      end else begin
        inValid = 1'b0;
      end
      hsPending = inValid && inReady;
    end
    clkPrev = cfgClk;
    csPrev  = cfgCs;
  endtask

  task automatic runLoad(input int n, input int iDelay, input int dAfter,
                         input int stallMax, input int busyHangAt,
                         input logic [1:0] expStatus, input string tag);
    int guard;
    nBytes = n; initDelay = iDelay; doneAfter = dAfter;
    for (int i = 0; i < 32; i++) begin
      tx[i] = 8'($urandom);
      cap[i] = 8'h00;
      stallTab[i] = (stallMax > 0) ? int'($urandom % (stallMax + 1)) : 0;
    end
    if (busyHangAt >= 0) stallTab[busyHangAt] = NEVER;
    idx = 0; capIdx = 0; progCnt = 0; waitCnt = 0; initCnt = 0; lowCnt = 0;
    dEdges = 0; abortCnt = 0; stallLeft = 0;
    holdVio = 0; earlyVio = 0; csWrVio = 0; widthVio = 0; readyVio = 0;
    csEver = 0; inStall = 0; hsPending = 0;
    tgtBusy = 1'b0; tgtDone = 1'b0; inValid = 1'b0;
    armed = 1'b1;
    byteCount = CNT_W'(n);
    start = 1'b1;
    tick();
    start = 1'b0;
    guard = 0;
    while (!finished && guard < 30000) begin
      tick();
      guard++;
    end
    chk(status == expStatus, {tag, " R9 status"}, int'(status), int'(expStatus));
    chk(abortCnt == ((expStatus != 2'b00) ? 1 : 0), {tag, " R9 abort"}, abortCnt,
        (expStatus != 2'b00) ? 1 : 0);
    chk(progCnt == PROGC, {tag, " R1 prog width"}, progCnt, PROGC);
    chk(csWrVio == 0, {tag, " R3 cs/wr/clk order"}, csWrVio, 0);
    chk(widthVio == 0, {tag, " R4 low width"}, widthVio, 0);
    chk(holdVio == 0, {tag, " R5 byte held"}, holdVio, 0);
    chk(earlyVio == 0, {tag, " R6 edge with wrong cs"}, earlyVio, 0);
    chk(readyVio == 0, {tag, " R8 ready gating"}, readyVio, 0);
    if (expStatus == 2'b00) begin
      int bad;
      bad = 0;
      for (int i = 0; i < n; i++) if (cap[i] != tx[i]) bad++;
      chk(capIdx == n, {tag, " R4 byte count"}, capIdx, n);
      chk(bad == 0, {tag, " R4 byte order"}, bad, 0);
      chk(idx == n, {tag, " R8 stream consumed"}, idx, n);
      chk(dEdges == dAfter, {tag, " R7 done pulses"}, dEdges, dAfter);
    end
    if (expStatus == 2'b01)
      chk(waitCnt == TOUT, {tag, " R2 ready wait"}, waitCnt, TOUT);
    for (int i = 0; i < 5; i++) tick();
    chk(finished && status == expStatus, {tag, " R9 result held"}, int'(status),
        int'(expStatus));
    armed = 1'b0;
    tgtBusy = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    armed = 0; clkPrev = 1'b1; csPrev = 1'b0;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk({cfgProg, cfgCs, cfgWr, cfgClk, inReady, finished, abort} == 7'b0001000 &&
        status == 2'b00, "reset state", int'({cfgProg, cfgCs, cfgWr, cfgClk}), 1);

    // directed: plain load, no stalls, done after 2 edges
    runLoad(4, 3, 2, 0, -1, 2'b00, "plain R4");
    // directed: zero bytes goes straight to the tail (R6)
    runLoad(0, 1, 1, 0, -1, 2'b00, "zero R6");
    // directed: target already done at tail
    runLoad(1, 0, 0, 0, -1, 2'b00, "done0 R7");
    // ready timeout, then recovery (R2, R10)
    runLoad(3, NEVER, 1, 0, -1, 2'b01, "initTo R2");
    runLoad(5, 2, 1, 2, -1, 2'b00, "after fail R10");
    // busy never clears on byte 2 (R5)
    runLoad(6, 2, 1, 0, 2, 2'b10, "busyTo R5");
    runLoad(3, 4, 3, 3, -1, 2'b00, "recover R10");
    // done never arrives (R7)
    runLoad(2, 1, NEVER, 1, -1, 2'b11, "doneTo R7");
    // constrained random loads with stalls and stream gaps
    for (int k = 0; k < 8; k++)
      runLoad(1 + int'($urandom % 20), int'($urandom % 6), int'($urandom % 5), 3, -1,
              2'b00, "random R5");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule